// File: doc/BRIEF.md
# Incremental Voltage-Trim Loop Sequencer

This block runs a closed digital regulation loop around a feedback-biased converter. Each pass asks a serial ADC reader for one conversion and waits for the 12-bit measured code. It compares that code, as an unsigned number, with a 12-bit target, moves a 12-bit DAC code by at most one count, and then asks a serial DAC writer to send the code. The next pass begins as soon as the write completes, unless a programmable settling pause applies.

The correction has inverted sense. Raising the DAC code lowers the regulated output, so a reading below target lowers the DAC code and a reading above target raises it. The code stops at 0x000 and at 0xFFF and does not wrap. A host loads a new target with a strobe, and the loop adopts it only when a pass begins. Separate pause lengths after a raising step and after a lowering step let the loop rate match the converter's settling time. A step-direction output and a pass counter expose the loop's progress.

Top module: `trim_loop_ctrl`

## Requirements
- R1: While reset is held and on leaving it, `dac_code` is 0xFFF, `step_dir` is 00 and `pass_cnt` is 0. The active target is 0x000, and `rd_start` is high in the first cycle after reset is released.
- R2: `rd_start` is a one-cycle pulse that starts a pass. `wr_start` pulses exactly two cycles after the cycle in which `rd_done` is high. With no pause, the next `rd_start` comes in the cycle right after `wr_done` is high.
- R3: When the measured code is below the active target and `dac_code` is not 0x000, `dac_code` decreases by exactly one.
- R4: When the measured code is above the active target and `dac_code` is not 0xFFF, `dac_code` increases by exactly one.
- R5: When the measured code equals the target, `dac_code` keeps its value, and the write is still requested.
- R6: `dac_code` never wraps. A reading below target at 0x000, or above target at 0xFFF, leaves the code unchanged and reports hold.
- R7: The comparison is unsigned. A reading of 0x800 against a target of 0x7FF raises the code, and a reading of 0x7FF against 0x800 lowers it.
- R8: `tgt_load` always records `tgt_code` as the pending target. The active target takes the pending value only in a cycle where `rd_start` is high. A strobe in that same cycle applies at once, so a strobe at any other point in a pass does not affect that pass.
- R9: After `wr_done` the loop pauses. The pause is `up_wait` cycles after a raising step, `dn_wait` cycles after a lowering step, and none after a hold. Then `rd_start` pulses. A count of zero means no pause.
- R10: `step_dir` gives the result of the last pass: 01 for raised, 10 for lowered, 00 for held. `pass_cnt` rises by one per pass, wrapping, in the same cycle that `dac_code` and `step_dir` update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_code | input | CODE_W | Target code from the host |
| tgt_load | input | 1 | Strobe that records `tgt_code` as the pending target |
| up_wait | input | WAIT_W | Pause in cycles after a raising step |
| dn_wait | input | WAIT_W | Pause in cycles after a lowering step |
| rd_start | output | 1 | Conversion request to the ADC reader |
| rd_done | input | 1 | Reader has `rd_code` valid |
| rd_code | input | CODE_W | Measured code |
| wr_start | output | 1 | Send request to the DAC writer, carrying `dac_code` |
| wr_done | input | 1 | Writer finished |
| dac_code | output | CODE_W | Current DAC code |
| step_dir | output | 2 | Result of the last pass (00 hold, 01 raised, 10 lowered) |
| pass_cnt | output | PASS_W | Completed-adjust counter |

## Verification
Both saturation ends are the hardest to reach. Getting there takes thousands of single-count passes, driven through a plant model in the bench whose reading tracks the DAC code. The bench chooses an offset and target that cannot be reached, so the loop walks the full range and then sits against each limit. Target loads that must land exactly in a pass-start cycle, or inside a running pass, are timed from the bench's own prediction of when the next `rd_start` is due. Forced readings on either side of 0x800 probe the unsigned compare.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [2:0] {
        ST_RD_REQ  = 3'd0,
        ST_RD_WAIT = 3'd1,
        ST_ADJ     = 3'd2,
        ST_WR_REQ  = 3'd3,
        ST_WR_WAIT = 3'd4,
        ST_SETTLE  = 3'd5
    } loop_state_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } step_dir_e;
endpackage

// File: rtl/trim_step_calc.sv
module trim_step_calc
    import trim_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] meas,
    input  logic [CODE_W-1:0] target,
    input  logic [CODE_W-1:0] cur,
    output logic [CODE_W-1:0] nxt,
    output logic [1:0]        dir
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    // inverted sense: low reading lowers the code
    always_comb begin
        nxt = cur;
        dir = DIR_HOLD;
        if ((meas < target) && (cur != CODE_MIN)) begin
            nxt = cur - 1'b1;
            dir = DIR_DOWN;
        end else if ((meas > target) && (cur != CODE_MAX)) begin
            nxt = cur + 1'b1;
            dir = DIR_UP;
        end
    end
endmodule

// File: rtl/trim_target_latch.sv
module trim_target_latch #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              apply,
    output logic [CODE_W-1:0] active
);
    typedef struct packed {
        logic [CODE_W-1:0] pend;
        logic [CODE_W-1:0] act;
    } tgt_t;

    tgt_t tgt_d, tgt_q;

    always_comb begin
        tgt_d = tgt_q;
        if (load) tgt_d.pend = load_code;
        // a strobe coinciding with the pass start wins over the older value
        if (apply) tgt_d.act = load ? load_code : tgt_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    assign active = tgt_q.act;
endmodule

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == LAST);
endmodule

// File: rtl/trim_loop_ctrl.sv
module trim_loop_ctrl
    import trim_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int WAIT_W = 16,
    parameter int PASS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              tgt_load,
    input  logic [WAIT_W-1:0] up_wait,
    input  logic [WAIT_W-1:0] dn_wait,
    output logic              rd_start,
    input  logic              rd_done,
    input  logic [CODE_W-1:0] rd_code,
    output logic              wr_start,
    input  logic              wr_done,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        step_dir,
    output logic [PASS_W-1:0] pass_cnt
);
    typedef struct packed {
        loop_state_e       st;
        logic [CODE_W-1:0] meas;
        logic [CODE_W-1:0] dac;
        logic [1:0]        dir;
        logic [PASS_W-1:0] pass;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:   ST_RD_REQ,
        meas: '0,
        dac:  '1,
        dir:  DIR_HOLD,
        pass: '0
    };

    ctl_t              ctl_d, ctl_q;
    logic [CODE_W-1:0] tgt_act;
    logic [CODE_W-1:0] calc_nxt;
    logic [1:0]        calc_dir;
    logic              tmr_load;
    logic              tmr_expire;
    logic [WAIT_W-1:0] wait_sel;

    trim_target_latch #(.CODE_W(CODE_W)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tgt_load),
        .load_code (tgt_code),
        .apply     (ctl_q.st == ST_RD_REQ),
        .active    (tgt_act)
    );

    trim_step_calc #(.CODE_W(CODE_W)) u_calc (
        .meas   (ctl_q.meas),
        .target (tgt_act),
        .cur    (ctl_q.dac),
        .nxt    (calc_nxt),
        .dir    (calc_dir)
    );

    trim_settle_timer #(.CNT_W(WAIT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (wait_sel),
        .expire   (tmr_expire)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        wait_sel = '0;
        case (ctl_q.st)
            ST_RD_REQ: ctl_d.st = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (rd_done) begin
                    ctl_d.meas = rd_code;
                    ctl_d.st   = ST_ADJ;
                end
            end
            ST_ADJ: begin
                ctl_d.dac  = calc_nxt;
                ctl_d.dir  = calc_dir;
                ctl_d.pass = ctl_q.pass + 1'b1;
                ctl_d.st   = ST_WR_REQ;
            end
            ST_WR_REQ: ctl_d.st = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (wr_done) begin
                    if (ctl_q.dir == DIR_UP)        wait_sel = up_wait;
                    else if (ctl_q.dir == DIR_DOWN) wait_sel = dn_wait;
                    if (wait_sel != '0) begin
                        tmr_load = 1'b1;
                        ctl_d.st = ST_SETTLE;
                    end else begin
                        ctl_d.st = ST_RD_REQ;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expire) ctl_d.st = ST_RD_REQ;
            end
            default: ctl_d.st = ST_RD_REQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rd_start = (ctl_q.st == ST_RD_REQ);
    assign wr_start = (ctl_q.st == ST_WR_REQ);
    assign dac_code = ctl_q.dac;
    assign step_dir = ctl_q.dir;
    assign pass_cnt = ctl_q.pass;
endmodule

// File: rtl/trim_loop_ctrl_sva.sv
module trim_loop_ctrl_sva #(
    parameter int CODE_W = 12,
    parameter int PASS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_start,
    input logic              wr_start,
    input logic [CODE_W-1:0] dac_code,
    input logic [1:0]        step_dir,
    input logic [PASS_W-1:0] pass_cnt,
    input logic [CODE_W-1:0] tgt_act
);
    p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && wr_start));

    p_down_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_code) && step_dir == 2'b10) |-> dac_code == $past(dac_code) - 1'b1);

    p_up_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_code) && step_dir == 2'b01) |-> dac_code == $past(dac_code) + 1'b1);

    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dir == 2'b00) |-> $stable(dac_code));

    p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&dac_code) |-> dac_code != '0);

    p_no_wrap_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dac_code == '0) |-> !(&dac_code));

    p_tgt_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt_act) |-> $past(rd_start));

    p_pass_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_cnt) |-> pass_cnt == $past(pass_cnt) + 1'b1);

    p_dac_with_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> !$stable(pass_cnt));

    p_dir_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step_dir != 2'b11);
endmodule

bind trim_loop_ctrl trim_loop_ctrl_sva #(.CODE_W(CODE_W), .PASS_W(PASS_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .wr_start (wr_start),
    .dac_code (dac_code),
    .step_dir (step_dir),
    .pass_cnt (pass_cnt),
    .tgt_act  (tgt_act)
);

// File: tb/trim_loop_ctrl_test.sv
module trim_loop_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] tgt_code = '0;
    logic        tgt_load = 1'b0;
    logic [15:0] up_wait = '0;
    logic [15:0] dn_wait = '0;
    logic        rd_start;
    logic        rd_done = 1'b0;
    logic [11:0] rd_code = '0;
    logic        wr_start;
    logic        wr_done = 1'b0;
    logic [11:0] dac_code;
    logic [1:0]  step_dir;
    logic [15:0] pass_cnt;

    always #10 clk = ~clk;

    trim_loop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .tgt_load(tgt_load),
        .up_wait(up_wait), .dn_wait(dn_wait), .rd_start(rd_start), .rd_done(rd_done),
        .rd_code(rd_code), .wr_start(wr_start), .wr_done(wr_done),
        .dac_code(dac_code), .step_dir(step_dir), .pass_cnt(pass_cnt)
    );

    int checks = 0, errors = 0;
    int cyc = -1;
    // behavioural model
    int m_dac = 4095, m_dir = 0, m_pass = 0, m_tgt = 0, m_pend = 0;
    int n_dac = 0, n_dir = 0;
    int passes = 0;
    int exp_rd_at = 0, exp_wr_at = -10, upd_at = -10, rd_due = -10, wr_due = -10;
    int rd_lat = 1, wr_lat = 1, bias = 0, force_meas = -1;
    int uw = 0, dw = 0;
    bit req_load = 0;
    int req_code = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
        end
    endtask

    function automatic int plant();
        int v;
        v = (force_meas >= 0) ? force_meas : 4095 - m_dac + bias;
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    endtask

    task automatic tick();
        int meas, w;
        @(negedge clk);
        rst_n = 1'b1;
        cyc++;
        tgt_load = req_load;
        tgt_code = 12'(req_code);
        req_load = 0;
        up_wait = 16'(uw);
        dn_wait = 16'(dw);
        if (cyc == upd_at) begin
            m_dac = n_dac; m_dir = n_dir; m_pass = (m_pass + 1) % 65536; passes++;
        end
        chk(rd_start == (cyc == exp_rd_at), "R2/R9/R1 rd_start", int'(rd_start), int'(cyc == exp_rd_at));
        chk(wr_start == (cyc == exp_wr_at), "R2/R5 wr_start", int'(wr_start), int'(cyc == exp_wr_at));
        chk(int'(dac_code) == m_dac, "R3/R4/R5/R6/R7/R8 dac_code", int'(dac_code), m_dac);
        chk(int'(step_dir) == m_dir, "R10 step_dir", int'(step_dir), m_dir);
        chk(int'(pass_cnt) == m_pass, "R10 pass_cnt", int'(pass_cnt), m_pass);
        rd_done = 1'b0;
        wr_done = 1'b0;
        if (cyc == exp_rd_at) begin
            m_tgt = tgt_load ? int'(tgt_code) : m_pend;
            rd_due = cyc + rd_lat;
        end
        if (tgt_load) m_pend = int'(tgt_code);
        if (cyc == rd_due) begin
            meas = plant();
            rd_done = 1'b1;
            rd_code = 12'(meas);
            n_dac = m_dac; n_dir = 0;
            if (meas < m_tgt && m_dac > 0) begin n_dac = m_dac - 1; n_dir = 2; end
            else if (meas > m_tgt && m_dac < 4095) begin n_dac = m_dac + 1; n_dir = 1; end
            upd_at = cyc + 2;
            exp_wr_at = cyc + 2;
        end
        if (cyc == exp_wr_at) wr_due = cyc + wr_lat;
        if (cyc == wr_due) begin
            wr_done = 1'b1;
            w = (m_dir == 1) ? uw : (m_dir == 2) ? dw : 0;
            exp_rd_at = cyc + 1 + w;
        end
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual cycle %0d expected below 190000", cyc);
            finish_run();
        end
    endtask

    task automatic run_passes(input int n);
        int goal;
        goal = passes + n;
        while (passes < goal) tick();
    endtask

    task automatic to_pass_start();
        while (exp_rd_at != cyc + 1) tick();
    endtask

    initial begin
        int p0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dac_code == 12'hFFF, "R1 reset dac_code", int'(dac_code), 4095);
        chk(step_dir == 2'b00, "R1 reset step_dir", int'(step_dir), 0);
        chk(pass_cnt == 16'd0, "R1 reset pass_cnt", int'(pass_cnt), 0);

        // target 0 and reading 0: equal, hold, still written (R5)
        run_passes(5);
        chk(dac_code == 12'hFFF, "R5 hold at equality", int'(dac_code), 4095);
        chk(step_dir == 2'b00, "R5 hold dir", int'(step_dir), 0);

        // converge down with latencies and pauses (R3, R9)
        rd_lat = 2; wr_lat = 3; uw = 7; dw = 3;
        req_load = 1; req_code = 1000;
        p0 = int'(pass_cnt);
        run_passes(1100);
        chk(dac_code == 12'd3095, "R3 converged code", int'(dac_code), 3095);
        chk(step_dir == 2'b00, "R3 settled hold", int'(step_dir), 0);
        chk(int'(pass_cnt) == (p0 + 1100) % 65536, "R10 pass count", int'(pass_cnt), (p0 + 1100) % 65536);

        // converge up (R4, R9)
        req_load = 1; req_code = 900;
        run_passes(150);
        chk(dac_code == 12'd3195, "R4 converged code", int'(dac_code), 3195);

        // unsigned compare (R7)
        rd_lat = 3;
        to_pass_start();
        force_meas = 12'h800; req_load = 1; req_code = 12'h7FF;
        run_passes(1);
        chk(step_dir == 2'b01, "R7 0x800 above 0x7FF", int'(step_dir), 1);
        to_pass_start();
        force_meas = 12'h7FF; req_load = 1; req_code = 12'h800;
        run_passes(1);
        chk(step_dir == 2'b10, "R7 0x7FF below 0x800", int'(step_dir), 2);

        // target capture timing (R8)
        force_meas = 12'h500;
        to_pass_start();
        req_load = 1; req_code = 12'h600;
        run_passes(1);
        chk(step_dir == 2'b10, "R8 load at pass start applies", int'(step_dir), 2);
        to_pass_start();
        tick();
        req_load = 1; req_code = 12'h400;
        run_passes(1);
        chk(step_dir == 2'b10, "R8 mid-pass load deferred", int'(step_dir), 2);
        run_passes(1);
        chk(step_dir == 2'b01, "R8 deferred load used next pass", int'(step_dir), 1);
        force_meas = -1;

        // low saturation (R6), zero pauses (R9)
        rd_lat = 1; wr_lat = 1; uw = 0; dw = 0; bias = -100;
        req_load = 1; req_code = 4095;
        run_passes(3400);
        chk(dac_code == 12'h000, "R6 floor", int'(dac_code), 0);
        chk(step_dir == 2'b00, "R6 floor hold", int'(step_dir), 0);

        // high saturation (R6)
        bias = 200; uw = 2;
        req_load = 1; req_code = 0;
        run_passes(4200);
        chk(dac_code == 12'hFFF, "R6 ceiling", int'(dac_code), 4095);
        chk(step_dir == 2'b00, "R6 ceiling hold", int'(step_dir), 0);

        repeat (10) tick();
        finish_run();
    end
endmodule